// File: doc/BRIEF.md
# Power-On Reset and Watchdog Supervisor

This block drives one active-low reset line for the rest of a system. It holds that line low after a cold start, whenever an external low-supply comparator reports that the supply is under its threshold, and after a watchdog timeout. Every release of reset waits for the same start-up delay. The delay starts on a cold start, when the low-supply indication goes away, and when the watchdog expires.

Time is measured in pulses of a slow single-cycle enable, `tickEn`, such as a 100 Hz strobe that comes from a clock divider elsewhere. At 100 Hz the default parameters give a 250 ms start-up delay and watchdog windows of 1.75 s, 0.75 s and 0.25 s. A fourth selection code switches the watchdog off. Software restarts the watchdog window with a single-cycle kick strobe. It changes the window through a two-bit selection and a write strobe. The analog comparator is not part of this block. Its result arrives as a synchronous digital input.

Top module: `reset_supervisor`

## Requirements
- R1: While `coldRstN` is low, `supResetN` is low at once. After `coldRstN` rises, `supResetN` stays low through `DELAY_TICKS` tick enables. It goes high on the clock edge that samples the last of those ticks.
- R2: While `lowVolt` is high, `supResetN` is low from the first clock edge that samples it. Ticks do not release it during that time.
- R3: After `lowVolt` falls, `supResetN` stays low for a fresh `DELAY_TICKS` ticks. It rises on the edge that samples the last of them.
- R4: While reset is released, the watchdog counts ticks. Period code 2'b00 expires after `LONG_TICKS` ticks, 2'b01 after `MID_TICKS` and 2'b10 after `SHORT_TICKS`. On the edge that samples the expiring tick, `supResetN` goes low.
- R5: A watchdog expiry holds reset low for `DELAY_TICKS` ticks. The watchdog count is held at zero while reset is low. Its next window starts from zero after the release.
- R6: A `kick` strobe clears the watchdog count. A kick that arrives in the same cycle as the tick that would expire the window wins, and no reset is issued.
- R7: A `periodWr` strobe loads `periodSel`. When the new code differs from the stored one, the count is cleared. A write of the code already stored leaves the count running.
- R8: Period code 2'b11 disables the watchdog. No number of ticks without kicks brings reset low.
- R9: A cold start sets the stored period code to 2'b00, the longest window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| coldRstN | input | 1 | Asynchronous active-low cold-start indication |
| tickEn | input | 1 | Single-cycle time-base enable that counts delay and watchdog time |
| lowVolt | input | 1 | High while the supply is below its trip threshold |
| kick | input | 1 | Single-cycle watchdog restart strobe |
| periodWr | input | 1 | Single-cycle write strobe for the period selection |
| periodSel | input | 2 | Period code: 00 long, 01 mid, 10 short, 11 off |
| supResetN | output | 1 | Active-low reset output |

## Verification
The bench builds the block with a 4-tick start-up delay and watchdog windows of 3, 5 and 7 ticks. With these values every expiry, every release and the same-cycle kick-and-tick race can be reached within a few dozen ticks. The small, distinct window lengths also make a wrong code-to-window mapping visible, because each code expires at a different tick count. A 20-tick idle run with the watchdog disabled covers all three windows, so any leftover counting would show up.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_DELAY = 2'd0,
    ST_LOWV  = 2'd1,
    ST_RUN   = 2'd2
  } supState_e;

  typedef struct packed {
    logic delayClr;
    logic delayInc;
    logic wdtClr;
    logic wdtInc;
  } supStrobes_t;

  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int DELAY_TICKS = 25,
  parameter int SHORT_TICKS = 25,
  parameter int MID_TICKS   = 75,
  parameter int LONG_TICKS  = 175,
  localparam int DLY_W = $clog2(DELAY_TICKS + 1),
  localparam int WDT_W = $clog2(LONG_TICKS + 1)
) (
  input  logic             clk,
  input  logic             coldRstN,
  input  supStrobes_t      strobes,
  input  logic             periodWr,
  input  logic [1:0]       periodSelIn,
  output logic             delayDone,
  output logic             wdtDone,
  output logic             wdtEnabled,
  output logic             selChange,
  output logic [WDT_W-1:0] wdtCount
);

  localparam logic [DLY_W-1:0] DELAY_LAST = DLY_W'(DELAY_TICKS - 1);
  localparam logic [WDT_W-1:0] SHORT_LAST = WDT_W'(SHORT_TICKS - 1);
  localparam logic [WDT_W-1:0] MID_LAST   = WDT_W'(MID_TICKS - 1);
  localparam logic [WDT_W-1:0] LONG_LAST  = WDT_W'(LONG_TICKS - 1);

  logic [DLY_W-1:0] delayCount;
  logic [1:0]       periodReg;
  logic [WDT_W-1:0] wdtLast;

  // Start-up delay counter, shared by all three release paths.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      delayCount <= '0;
    end else if (strobes.delayClr) begin
      delayCount <= '0;
    end else if (strobes.delayInc) begin
      delayCount <= delayCount + 1'b1;
    end
  end

  assign delayDone = (delayCount == DELAY_LAST);

  // Stored period code, loaded by every write.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      periodReg <= SEL_LONG;
    end else if (periodWr) begin
      periodReg <= periodSelIn;
    end
  end

  assign selChange  = periodWr && (periodSelIn != periodReg);
  assign wdtEnabled = (periodReg != SEL_OFF);

  always_comb begin
    case (periodReg)
      SEL_LONG:  wdtLast = LONG_LAST;
      SEL_MID:   wdtLast = MID_LAST;
      SEL_SHORT: wdtLast = SHORT_LAST;
      default:   wdtLast = '0;
    endcase
  end

  // Watchdog window counter.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      wdtCount <= '0;
    end else if (strobes.wdtClr) begin
      wdtCount <= '0;
    end else if (strobes.wdtInc) begin
      wdtCount <= wdtCount + 1'b1;
    end
  end

  assign wdtDone = wdtEnabled && (wdtCount == wdtLast);

  // R8: with the watchdog off the count never moves off zero.
  a_r8_off_stays_zero: assert property (@(posedge clk) disable iff (!coldRstN)
    (periodReg == SEL_OFF) |-> (wdtCount == '0));

  // R4: the count never passes the last value of the selected window.
  a_r4_count_in_window: assert property (@(posedge clk) disable iff (!coldRstN)
    wdtEnabled |-> (wdtCount <= wdtLast));

  // R1: the delay count never passes its last value.
  a_r1_delay_in_range: assert property (@(posedge clk) disable iff (!coldRstN)
    delayCount <= DELAY_LAST);

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        coldRstN,
  input  logic        tickEn,
  input  logic        lowVolt,
  input  logic        kick,
  input  logic        delayDone,
  input  logic        wdtDone,
  input  logic        wdtEnabled,
  input  logic        selChange,
  output supStrobes_t strobes,
  output logic        supResetN
);

  supState_e state;
  supState_e stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_DELAY: begin
        strobes.wdtClr = 1'b1;
        if (lowVolt) begin
          stateNext        = ST_LOWV;
          strobes.delayClr = 1'b1;
        end else if (tickEn) begin
          if (delayDone) begin
            stateNext        = ST_RUN;
            strobes.delayClr = 1'b1;
          end else begin
            strobes.delayInc = 1'b1;
          end
        end
      end
      ST_LOWV: begin
        strobes.wdtClr   = 1'b1;
        strobes.delayClr = 1'b1;
        if (!lowVolt) begin
          stateNext = ST_DELAY;
        end
      end
      ST_RUN: begin
        if (lowVolt) begin
          stateNext        = ST_LOWV;
          strobes.wdtClr   = 1'b1;
          strobes.delayClr = 1'b1;
        end else if (kick || selChange) begin
          strobes.wdtClr = 1'b1;
        end else if (tickEn && wdtEnabled) begin
          if (wdtDone) begin
            stateNext        = ST_DELAY;
            strobes.wdtClr   = 1'b1;
            strobes.delayClr = 1'b1;
          end else begin
            strobes.wdtInc = 1'b1;
          end
        end
      end
      default: begin
        stateNext        = ST_DELAY;
        strobes.wdtClr   = 1'b1;
        strobes.delayClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      state     <= ST_DELAY;
      supResetN <= 1'b0;
    end else begin
      state     <= stateNext;
      supResetN <= (stateNext == ST_RUN);
    end
  end

  // R2: a low-supply sample forces reset on the next edge.
  a_r2_lowv_forces_reset: assert property (@(posedge clk) disable iff (!coldRstN)
    lowVolt |=> !supResetN);

  // R3: reset only ever releases on a tick with the supply good.
  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!coldRstN)
    $rose(supResetN) |-> $past(tickEn && !lowVolt));

  // R6: a kick in run never turns into a watchdog reset.
  a_r6_kick_blocks_expiry: assert property (@(posedge clk) disable iff (!coldRstN)
    (supResetN && kick && !lowVolt) |=> supResetN);

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import supv_pkg::*;
#(
  parameter int DELAY_TICKS = 25,
  parameter int SHORT_TICKS = 25,
  parameter int MID_TICKS   = 75,
  parameter int LONG_TICKS  = 175
) (
  input  logic       clk,
  input  logic       coldRstN,
  input  logic       tickEn,
  input  logic       lowVolt,
  input  logic       kick,
  input  logic       periodWr,
  input  logic [1:0] periodSel,
  output logic       supResetN
);

  localparam int WDT_W = $clog2(LONG_TICKS + 1);

  supStrobes_t      strobes;
  logic             delayDone;
  logic             wdtDone;
  logic             wdtEnabled;
  logic             selChange;
  logic [WDT_W-1:0] wdtCount;

  supv_control u_control (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .tickEn     (tickEn),
    .lowVolt    (lowVolt),
    .kick       (kick),
    .delayDone  (delayDone),
    .wdtDone    (wdtDone),
    .wdtEnabled (wdtEnabled),
    .selChange  (selChange),
    .strobes    (strobes),
    .supResetN  (supResetN)
  );

  supv_datapath #(
    .DELAY_TICKS (DELAY_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .MID_TICKS   (MID_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_datapath (
    .clk         (clk),
    .coldRstN    (coldRstN),
    .strobes     (strobes),
    .periodWr    (periodWr),
    .periodSelIn (periodSel),
    .delayDone   (delayDone),
    .wdtDone     (wdtDone),
    .wdtEnabled  (wdtEnabled),
    .selChange   (selChange),
    .wdtCount    (wdtCount)
  );

  // R5: the watchdog count stays at zero while reset is held.
  a_r5_count_held_in_reset: assert property (@(posedge clk) disable iff (!coldRstN)
    !supResetN |-> (wdtCount == '0));

  // R6: a kick leaves the count at zero on the next edge.
  a_r6_kick_clears: assert property (@(posedge clk) disable iff (!coldRstN)
    kick |=> (wdtCount == '0));

endmodule

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;

  localparam int DLY = 4;
  localparam int SHT = 3;
  localparam int MID = 5;
  localparam int LNG = 7;

  localparam logic [2:0] OP_CHK  = 3'd0;
  localparam logic [2:0] OP_TICK = 3'd1;
  localparam logic [2:0] OP_KICK = 3'd2;
  localparam logic [2:0] OP_WR   = 3'd3;
  localparam logic [2:0] OP_LV   = 3'd4;
  localparam logic [2:0] OP_KT   = 3'd5;

  localparam int NV = 64;
  // {op, arg, expected supResetN, requirement number}
  localparam logic [15:0] VEC [NV] = '{
    {OP_CHK,  8'd0,  1'b0, 4'd1},  // R1 held after cold start
    {OP_TICK, 8'd3,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd1},  // R1 one tick short
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd1},  // R1 released
    {OP_TICK, 8'd6,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd4},  // R4 long window not yet over
    {OP_KICK, 8'd0,  1'b0, 4'd0},
    {OP_TICK, 8'd6,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd6},  // R6 kick restarted the window
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd4},  // R4 long window expiry
    {OP_TICK, 8'd3,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd5},  // R5 still held
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd5},  // R5 released after the delay
    {OP_WR,   8'd2,  1'b0, 4'd0},
    {OP_TICK, 8'd2,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd4},  // R4 short window not over
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd4},  // R4 short window expiry
    {OP_TICK, 8'd4,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd5},  // R5 released
    {OP_WR,   8'd1,  1'b0, 4'd0},
    {OP_TICK, 8'd4,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd4},  // R4 mid window not over
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd4},  // R4 mid window expiry
    {OP_TICK, 8'd7,  1'b0, 4'd0},  // release, then 3 ticks counted
    {OP_WR,   8'd1,  1'b0, 4'd0},  // same code, no clear
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd7},  // R7 count at 4
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd7},  // R7 same-code write kept the count
    {OP_TICK, 8'd8,  1'b0, 4'd0},  // release, then 4 ticks counted
    {OP_WR,   8'd2,  1'b0, 4'd0},  // new code clears
    {OP_TICK, 8'd2,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd7},  // R7 cleared by the code change
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd7},  // R7 new short window expiry
    {OP_TICK, 8'd4,  1'b0, 4'd0},
    {OP_WR,   8'd3,  1'b0, 4'd0},
    {OP_TICK, 8'd20, 1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd8},  // R8 disabled watchdog never fires
    {OP_WR,   8'd2,  1'b0, 4'd0},
    {OP_LV,   8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd2},  // R2 low supply forces reset
    {OP_TICK, 8'd10, 1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd2},  // R2 ticks do not release
    {OP_LV,   8'd0,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd3},  // R3 still held after release of lowVolt
    {OP_TICK, 8'd3,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd3},  // R3 one tick short
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd3},  // R3 released after fresh delay
    {OP_TICK, 8'd2,  1'b0, 4'd0},
    {OP_KT,   8'd0,  1'b0, 4'd0},  // kick and expiring tick together
    {OP_CHK,  8'd0,  1'b1, 4'd6},  // R6 kick won the race
    {OP_TICK, 8'd2,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd6},  // R6 window restarted at zero
    {OP_TICK, 8'd1,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b0, 4'd6},  // R6 expiry a full window later
    {OP_TICK, 8'd4,  1'b0, 4'd0},
    {OP_CHK,  8'd0,  1'b1, 4'd5}   // R5 released
  };

  logic       clk = 1'b0;
  logic       coldRstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       lowVolt = 1'b0;
  logic       kick = 1'b0;
  logic       periodWr = 1'b0;
  logic [1:0] periodSel = 2'b00;
  logic       supResetN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  reset_supervisor #(
    .DELAY_TICKS (DLY),
    .SHORT_TICKS (SHT),
    .MID_TICKS   (MID),
    .LONG_TICKS  (LNG)
  ) i_reset_supervisor (
    .clk       (clk),
    .coldRstN  (coldRstN),
    .tickEn    (tickEn),
    .lowVolt   (lowVolt),
    .kick      (kick),
    .periodWr  (periodWr),
    .periodSel (periodSel),
    .supResetN (supResetN)
  );

  task automatic check(input logic exp, input int req);
    checks++;
    if (supResetN !== exp) begin
      fails++;
      $display("FAIL R%0d: supResetN=%b expected %b at %0t", req, supResetN, exp, $time);
    end
  endtask

  task automatic doTicks(input int n);
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    coldRstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] arg;
      op  = VEC[i][15:13];
      arg = VEC[i][12:5];
      case (op)
        OP_CHK:  check(VEC[i][4], int'(VEC[i][3:0]));
        OP_TICK: doTicks(int'(arg));
        OP_KICK: begin
          kick = 1'b1; @(posedge clk); @(negedge clk); kick = 1'b0;
        end
        OP_WR: begin
          periodSel = arg[1:0]; periodWr = 1'b1;
          @(posedge clk); @(negedge clk); periodWr = 1'b0;
        end
        OP_LV: begin
          lowVolt = arg[0]; @(posedge clk); @(negedge clk);
        end
        OP_KT: begin
          kick = 1'b1; tickEn = 1'b1;
          @(posedge clk); @(negedge clk);
          kick = 1'b0; tickEn = 1'b0;
        end
        default: ;
      endcase
    end

    // R1: a cold start pulls reset low without waiting for a clock edge.
    #1 coldRstN = 1'b0;
    #0.5 check(1'b0, 1);
    @(negedge clk);
    periodSel = 2'b10;
    coldRstN = 1'b1;
    // R9: the period code returns to the long window after a cold start.
    doTicks(DLY);
    check(1'b1, 9);
    doTicks(LNG - 1);
    check(1'b1, 9);
    doTicks(1);
    check(1'b0, 9);
    // R5: kicks during the hold neither release nor shorten it.
    kick = 1'b1; @(posedge clk); @(negedge clk); kick = 1'b0;
    doTicks(DLY - 1);
    check(1'b0, 5);
    doTicks(1);
    check(1'b1, 5);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finishRun();
  end

endmodule